// File: doc/BRIEF.md
# Reset Request Arbiter and Architectural State Loader

This block sits beside a small processor core. It collects every source that can reset the core and sorts them into power-on and manual resets. It then steps the core's architectural reset state into place in a fixed order. There are three sources. The first is an active-low external reset pin, which is brought into the clock domain through a synchronizer chain. The second is a pulse from the watchdog counter when it overflows, qualified by a timer-mode bit and a reset-kind bit. The third is a reset request from the debug port.

A reset does its work in this order. The event code is written first. Next the vector base and the status fields are written. A module-initialization window of `INIT_CYCLES` clocks follows. The program counter is loaded with the uncached boot vector last, and the core is released to run. When the watchdog is in interval mode, its overflow produces only an interrupt pulse. A cause code records which source started the most recent reset.

Top module: `rstreq_init`

## Requirements
- R1: While `ext_rst_n` is low, `por_active_o` is 1 at once, without waiting for a clock edge. The registers are cleared and `cause_o` is 0 (pin). After the pin goes high, the hold phase ends on the third rising clock edge, with `SYNC_STAGES`=2.
- R2: Suppose the core is running and `wdt_ovf` is seen at an edge with `wdt_mode`=1 and `wdt_rsel`=0. Then `por_active_o` is 1 after that edge and `cause_o` is 2.
- R3: `dbg_rst_req` requests a power-on reset and sets `cause_o` to 1. For as long as it stays high, the block stays in the hold phase with `running_o`=0.
- R4: On the first edge after the hold phase ends, `expevt_o` is loaded. The value is 12'h000 for a power-on reset and 12'h020 for a manual reset. Nothing else changes at that edge.
- R5: On the second edge after the hold phase ends, `vbr_o` becomes 0 and the status fields become md=1, rb=1, bl=1, fd=0 and imask=4'b1111.
- R6: `init_req_o` is 1 for exactly `INIT_CYCLES` cycles. It starts with the second edge after the hold phase ends, so the status fields are already loaded while it is high.
- R7: On edge 3+`INIT_CYCLES` after the hold phase ends, `pc_o` becomes 32'hA000_0000 and `running_o` becomes 1. At the same edge, `por_active_o` and `mrst_active_o` fall. Before that edge, `pc_o` keeps its earlier value.
- R8: A `wdt_ovf` with `wdt_mode`=1 and `wdt_rsel`=1 starts a manual reset. `mrst_active_o` is 1 and `cause_o` is 3, and the sequence is the same as for a power-on reset.
- R9: When `wdt_mode`=0, `itv_irq_o` follows `wdt_ovf` in the same cycle. In that mode an overflow causes no reset, and `running_o` stays 1.
- R10: When power-on and manual requests arrive in the same cycle, the power-on reset wins. A manual request made during a power-on sequence is ignored. A power-on request made during a manual sequence restarts the sequence as a power-on reset.
- R11: When several power-on sources are active together, `cause_o` takes the pin first, then the debug request, then the watchdog. It stays unchanged until the next reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog counter overflow pulse |
| wdt_mode | input | 1 | 1 = watchdog mode, 0 = interval-timer mode |
| wdt_rsel | input | 1 | In watchdog mode: 0 = power-on, 1 = manual |
| dbg_rst_req | input | 1 | Reset request from the debug port |
| por_active_o | output | 1 | A power-on reset sequence is in progress |
| mrst_active_o | output | 1 | A manual reset sequence is in progress |
| itv_irq_o | output | 1 | Interval-timer interrupt pulse |
| init_req_o | output | 1 | Module initialization window |
| running_o | output | 1 | Core released to run |
| cause_o | output | 2 | Last reset cause: 0 pin, 1 debug, 2 watchdog power-on, 3 watchdog manual |
| expevt_o | output | 12 | Exception event code |
| vbr_o | output | 32 | Vector base register |
| sr_md_o | output | 1 | Status: privileged mode bit |
| sr_rb_o | output | 1 | Status: register bank select |
| sr_bl_o | output | 1 | Status: exception block bit |
| sr_fd_o | output | 1 | Status: FPU disable bit |
| sr_imask_o | output | 4 | Status: interrupt mask level |
| pc_o | output | 32 | Program counter / branch target |

## Verification
The bench tries all sixteen combinations of debug request, overflow, mode bit and reset-kind bit from the running state. It checks the reset kind and the cause code against each. A decoder that swapped the meaning of `wdt_rsel` would give the wrong kind here. So would one that let interval mode reset the core, or one that let a manual reset win over a power-on reset.

Each reset is followed edge by edge. This finds any step done out of order, such as the program counter loaded before the status fields, or any initialization window that is too long or too short. It also finds a synchronizer with a stage missing, which would end the hold phase one edge early. Further cases request a manual reset inside a power-on sequence and a power-on reset inside a manual one. Another releases the pin while the debug request is held, which catches a priority order that records the wrong cause.

// File: rtl/rstreq_pkg.sv
package rstreq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_EVT    = 3'd1,
        ST_ARCH   = 3'd2,
        ST_INIT   = 3'd3,
        ST_BRANCH = 3'd4,
        ST_RUN    = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_PIN     = 2'd0,
        CAUSE_DBG     = 2'd1,
        CAUSE_WDT_POR = 2'd2,
        CAUSE_WDT_MAN = 2'd3
    } cause_e;

    typedef struct packed {
        logic       md;
        logic       rb;
        logic       bl;
        logic       fd;
        logic [3:0] imask;
    } stat_t;

    localparam stat_t STAT_CLEAR = '{md: 1'b0, rb: 1'b0, bl: 1'b0, fd: 1'b0, imask: 4'h0};
    localparam stat_t STAT_BOOT  = '{md: 1'b1, rb: 1'b1, bl: 1'b1, fd: 1'b0, imask: 4'hF};

endpackage

// File: rtl/rstreq_sync.sv
module rstreq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic pin_req
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = 1'b1;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
        end
    endgenerate

    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pin_req = ~chain_q[STAGES-1];
endmodule

// File: rtl/rstreq_decode.sv
module rstreq_decode
    import rstreq_pkg::*;
(
    input  logic   pin_req,
    input  logic   dbg_req,
    input  logic   wdt_ovf,
    input  logic   wdt_mode,
    input  logic   wdt_rsel,
    output logic   por_req,
    output logic   man_req,
    output cause_e por_cause,
    output logic   itv_irq
);
    logic wdt_por, wdt_man;

    always_comb begin
        wdt_por = wdt_ovf & wdt_mode & ~wdt_rsel;
        wdt_man = wdt_ovf & wdt_mode &  wdt_rsel;
        itv_irq = wdt_ovf & ~wdt_mode;
        por_req = pin_req | dbg_req | wdt_por;
        man_req = wdt_man & ~por_req;
        if (pin_req)      por_cause = CAUSE_PIN;
        else if (dbg_req) por_cause = CAUSE_DBG;
        else              por_cause = CAUSE_WDT_POR;
    end
endmodule

// File: rtl/rstreq_seq.sv
module rstreq_seq
    import rstreq_pkg::*;
#(
    parameter int          INIT_CYCLES = 4,
    parameter logic [31:0] VEC_ADDR    = 32'hA000_0000,
    parameter logic [11:0] POR_CODE    = 12'h000,
    parameter logic [11:0] MAN_CODE    = 12'h020
) (
    input  logic        clk,
    input  logic        arst_n,
    input  logic        por_req,
    input  logic        man_req,
    input  cause_e      por_cause,
    output logic        por_active,
    output logic        man_active,
    output logic        init_req,
    output logic        running,
    output cause_e      cause,
    output logic [11:0] expevt,
    output logic [31:0] vbr,
    output stat_t       stat,
    output logic [31:0] pc
);
    localparam int CNT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

    typedef struct packed {
        seq_state_e       state;
        logic             is_por;
        logic [CNT_W-1:0] cnt;
        cause_e           cause;
        logic [11:0]      expevt;
        logic [31:0]      vbr;
        stat_t            stat;
        logic [31:0]      pc;
    } seq_t;

    seq_t d, q;
    logic in_por_seq;

    always_comb begin
        d          = q;
        in_por_seq = q.is_por && (q.state != ST_RUN);
        if (por_req) begin
            d.state  = ST_HOLD;
            d.is_por = 1'b1;
            d.cause  = por_cause;
            d.cnt    = '0;
        end else if (man_req && !in_por_seq) begin
            d.state  = ST_HOLD;
            d.is_por = 1'b0;
            d.cause  = CAUSE_WDT_MAN;
            d.cnt    = '0;
        end else begin
            case (q.state)
                ST_HOLD: d.state = ST_EVT;
                ST_EVT: begin
                    d.expevt = q.is_por ? POR_CODE : MAN_CODE;
                    d.state  = ST_ARCH;
                end
                ST_ARCH: begin
                    d.vbr   = 32'h0;
                    d.stat  = STAT_BOOT;
                    d.cnt   = '0;
                    d.state = ST_INIT;
                end
                ST_INIT: begin
                    if (q.cnt == CNT_LAST) d.state = ST_BRANCH;
                    else                   d.cnt   = q.cnt + 1'b1;
                end
                ST_BRANCH: begin
                    d.pc    = VEC_ADDR;
                    d.state = ST_RUN;
                end
                default: d.state = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            q.state  <= ST_HOLD;
            q.is_por <= 1'b1;
            q.cnt    <= '0;
            q.cause  <= CAUSE_PIN;
            q.expevt <= 12'h0;
            q.vbr    <= 32'h0;
            q.stat   <= STAT_CLEAR;
            q.pc     <= 32'h0;
        end else begin
            q <= d;
        end
    end

    assign por_active = (q.state != ST_RUN) &&  q.is_por;
    assign man_active = (q.state != ST_RUN) && !q.is_por;
    assign init_req   = (q.state == ST_INIT);
    assign running    = (q.state == ST_RUN);
    assign cause      = q.cause;
    assign expevt     = q.expevt;
    assign vbr        = q.vbr;
    assign stat       = q.stat;
    assign pc         = q.pc;
endmodule

// File: rtl/rstreq_init.sv
module rstreq_init
    import rstreq_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          INIT_CYCLES = 4,
    parameter logic [31:0] VEC_ADDR    = 32'hA000_0000,
    parameter logic [11:0] POR_CODE    = 12'h000,
    parameter logic [11:0] MAN_CODE    = 12'h020
) (
    input  logic        clk,
    input  logic        ext_rst_n,
    input  logic        wdt_ovf,
    input  logic        wdt_mode,
    input  logic        wdt_rsel,
    input  logic        dbg_rst_req,
    output logic        por_active_o,
    output logic        mrst_active_o,
    output logic        itv_irq_o,
    output logic        init_req_o,
    output logic        running_o,
    output logic [1:0]  cause_o,
    output logic [11:0] expevt_o,
    output logic [31:0] vbr_o,
    output logic        sr_md_o,
    output logic        sr_rb_o,
    output logic        sr_bl_o,
    output logic        sr_fd_o,
    output logic [3:0]  sr_imask_o,
    output logic [31:0] pc_o
);
    logic   pin_req, por_req, man_req;
    cause_e por_cause, cause;
    stat_t  stat;

    rstreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .pin_n   (ext_rst_n),
        .pin_req (pin_req)
    );

    rstreq_decode u_dec (
        .pin_req   (pin_req),
        .dbg_req   (dbg_rst_req),
        .wdt_ovf   (wdt_ovf),
        .wdt_mode  (wdt_mode),
        .wdt_rsel  (wdt_rsel),
        .por_req   (por_req),
        .man_req   (man_req),
        .por_cause (por_cause),
        .itv_irq   (itv_irq_o)
    );

    rstreq_seq #(
        .INIT_CYCLES (INIT_CYCLES),
        .VEC_ADDR    (VEC_ADDR),
        .POR_CODE    (POR_CODE),
        .MAN_CODE    (MAN_CODE)
    ) u_seq (
        .clk        (clk),
        .arst_n     (ext_rst_n),
        .por_req    (por_req),
        .man_req    (man_req),
        .por_cause  (por_cause),
        .por_active (por_active_o),
        .man_active (mrst_active_o),
        .init_req   (init_req_o),
        .running    (running_o),
        .cause      (cause),
        .expevt     (expevt_o),
        .vbr        (vbr_o),
        .stat       (stat),
        .pc         (pc_o)
    );

    assign cause_o    = cause;
    assign sr_md_o    = stat.md;
    assign sr_rb_o    = stat.rb;
    assign sr_bl_o    = stat.bl;
    assign sr_fd_o    = stat.fd;
    assign sr_imask_o = stat.imask;
endmodule

// File: rtl/rstreq_init_chk.sv
module rstreq_init_chk #(
    parameter logic [31:0] VEC_ADDR = 32'hA000_0000,
    parameter logic [11:0] POR_CODE = 12'h000,
    parameter logic [11:0] MAN_CODE = 12'h020
) (
    input logic        clk,
    input logic        ext_rst_n,
    input logic        wdt_ovf,
    input logic        wdt_mode,
    input logic        wdt_rsel,
    input logic        dbg_rst_req,
    input logic        por_active_o,
    input logic        mrst_active_o,
    input logic        itv_irq_o,
    input logic        init_req_o,
    input logic        running_o,
    input logic [1:0]  cause_o,
    input logic [11:0] expevt_o,
    input logic [31:0] vbr_o,
    input logic        sr_md_o,
    input logic        sr_rb_o,
    input logic        sr_bl_o,
    input logic        sr_fd_o,
    input logic [3:0]  sr_imask_o,
    input logic [31:0] pc_o
);
    logic boot_stat;
    assign boot_stat = sr_md_o && sr_rb_o && sr_bl_o && !sr_fd_o && (sr_imask_o == 4'hF);

    AST_PIN_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $rose(ext_rst_n) |-> por_active_o); // R1
    AST_WDT_POR: assert property (@(posedge clk) disable iff (!ext_rst_n)
        running_o && wdt_ovf && wdt_mode && !wdt_rsel && !dbg_rst_req
        |=> por_active_o && (cause_o == 2'd2)); // R2
    AST_DBG_POR: assert property (@(posedge clk) disable iff (!ext_rst_n)
        running_o && dbg_rst_req |=> por_active_o && (cause_o == 2'd1)); // R3
    AST_RUN_STATE: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $rose(running_o) |-> (pc_o == VEC_ADDR) && (vbr_o == 32'h0) && boot_stat
                             && ((expevt_o == POR_CODE) || (expevt_o == MAN_CODE))); // R7
    AST_INIT_AFTER_STATUS: assert property (@(posedge clk) disable iff (!ext_rst_n)
        init_req_o |-> boot_stat && (vbr_o == 32'h0) && !running_o); // R6
    AST_WDT_MANUAL: assert property (@(posedge clk) disable iff (!ext_rst_n)
        running_o && wdt_ovf && wdt_mode && wdt_rsel && !dbg_rst_req
        |=> mrst_active_o && !por_active_o && (cause_o == 2'd3)); // R8
    AST_INTERVAL_NO_RESET: assert property (@(posedge clk) disable iff (!ext_rst_n)
        running_o && wdt_ovf && !wdt_mode && !dbg_rst_req |=> running_o); // R9
    AST_POR_OVER_MANUAL: assert property (@(posedge clk) disable iff (!ext_rst_n)
        wdt_ovf && wdt_mode && wdt_rsel && dbg_rst_req |=> por_active_o && !mrst_active_o); // R10
    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!ext_rst_n)
        running_o && $past(running_o) |-> $stable(cause_o)); // R11
endmodule

bind rstreq_init rstreq_init_chk #(
    .VEC_ADDR (VEC_ADDR),
    .POR_CODE (POR_CODE),
    .MAN_CODE (MAN_CODE)
) u_chk (.*);

// File: tb/rstreq_init_test.sv
`timescale 1ns/1ps
module rstreq_init_test;
    localparam int          N_INIT = 4;
    localparam logic [31:0] VEC    = 32'hA000_0000;
    localparam logic [11:0] C_POR  = 12'h000;
    localparam logic [11:0] C_MAN  = 12'h020;

    logic        clk = 1'b0;
    logic        ext_rst_n = 1'b1;
    logic        wdt_ovf = 1'b0, wdt_mode = 1'b0, wdt_rsel = 1'b0, dbg_rst_req = 1'b0;
    logic        por_active_o, mrst_active_o, itv_irq_o, init_req_o, running_o;
    logic [1:0]  cause_o;
    logic [11:0] expevt_o;
    logic [31:0] vbr_o, pc_o;
    logic        sr_md_o, sr_rb_o, sr_bl_o, sr_fd_o;
    logic [3:0]  sr_imask_o;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    rstreq_init #(.INIT_CYCLES(N_INIT)) uut (
        .clk(clk), .ext_rst_n(ext_rst_n), .wdt_ovf(wdt_ovf), .wdt_mode(wdt_mode),
        .wdt_rsel(wdt_rsel), .dbg_rst_req(dbg_rst_req), .por_active_o(por_active_o),
        .mrst_active_o(mrst_active_o), .itv_irq_o(itv_irq_o), .init_req_o(init_req_o),
        .running_o(running_o), .cause_o(cause_o), .expevt_o(expevt_o), .vbr_o(vbr_o),
        .sr_md_o(sr_md_o), .sr_rb_o(sr_rb_o), .sr_bl_o(sr_bl_o), .sr_fd_o(sr_fd_o),
        .sr_imask_o(sr_imask_o), .pc_o(pc_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp_v, $time);
        end
    endtask

    function automatic logic [7:0] stat_word();
        return {sr_md_o, sr_rb_o, sr_bl_o, sr_fd_o, sr_imask_o};
    endfunction

    // Called at the falling edge that follows the edge on which the hold phase ended.
    task automatic seq_check(input logic is_por, input logic [11:0] code,
                             input logic [1:0] cse, input logic first);
        chk("R7 active kind por", 32'(por_active_o), 32'(is_por));
        chk("R8 active kind manual", 32'(mrst_active_o), 32'(!is_por));
        @(negedge clk);
        chk("R4 event code", 32'(expevt_o), 32'(code));
        chk("R6 init not yet", 32'(init_req_o), 32'd0);
        if (first) chk("R5 status not yet loaded", 32'(stat_word()), 32'h00);
        @(negedge clk);
        chk("R5 vbr cleared", vbr_o, 32'h0);
        chk("R5 status pattern", 32'(stat_word()), 32'hEF);
        chk("R6 init window start", 32'(init_req_o), 32'd1);
        for (int i = 1; i < N_INIT; i++) begin
            @(negedge clk);
            chk("R6 init window body", 32'(init_req_o), 32'd1);
        end
        @(negedge clk);
        chk("R6 init window end", 32'(init_req_o), 32'd0);
        chk("R7 not yet running", 32'(running_o), 32'd0);
        if (first) chk("R7 pc not yet loaded", pc_o, 32'h0);
        @(negedge clk);
        chk("R7 pc vector", pc_o, VEC);
        chk("R7 running", 32'(running_o), 32'd1);
        chk("R7 actives drop", 32'({por_active_o, mrst_active_o}), 32'd0);
        chk("R11 cause kept", 32'(cause_o), 32'(cse));
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] prev_cause;
        #2 ext_rst_n = 1'b0;
        #1;
        chk("R1 async por", 32'(por_active_o), 32'd1);
        repeat (3) @(negedge clk);
        chk("R1 reset running", 32'(running_o), 32'd0);
        chk("R1 reset cause", 32'(cause_o), 32'd0);
        chk("R1 reset pc", pc_o, 32'h0);
        chk("R1 reset status", 32'(stat_word()), 32'h00);
        ext_rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 still holding after sync", 32'(por_active_o), 32'd1);
        @(negedge clk);
        seq_check(1'b1, C_POR, 2'd0, 1'b1);

        // exhaustive sweep of {dbg, ovf, mode, rsel} from running
        prev_cause = 2'd0;
        for (int v = 0; v < 16; v++) begin
            logic dbg, ovf, mode, rsel, e_por, e_man;
            logic [1:0] e_cause;
            {dbg, ovf, mode, rsel} = 4'(v);
            e_por = dbg | (ovf & mode & !rsel);
            e_man = !e_por & ovf & mode & rsel;
            e_cause = dbg ? 2'd1 : (e_por ? 2'd2 : (e_man ? 2'd3 : prev_cause));
            @(negedge clk);
            dbg_rst_req = dbg; wdt_ovf = ovf; wdt_mode = mode; wdt_rsel = rsel;
            #1;
            chk("R9 interval irq", 32'(itv_irq_o), 32'(ovf & !mode));
            @(negedge clk);
            dbg_rst_req = 1'b0; wdt_ovf = 1'b0; wdt_mode = 1'b0; wdt_rsel = 1'b0;
            chk("R2 R3 sweep por", 32'(por_active_o), 32'(e_por));
            chk("R8 R10 sweep manual", 32'(mrst_active_o), 32'(e_man));
            chk("R9 sweep running", 32'(running_o), 32'(!(e_por | e_man)));
            chk("R11 sweep cause", 32'(cause_o), 32'(e_cause));
            prev_cause = e_cause;
            if (e_por | e_man) begin
                @(negedge clk);
                seq_check(e_por, e_por ? C_POR : C_MAN, e_cause, 1'b0);
            end
        end

        // R3: held debug request keeps the hold phase
        @(negedge clk);
        dbg_rst_req = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk("R3 held debug keeps hold", 32'({por_active_o, running_o}), 32'b10);
        end
        dbg_rst_req = 1'b0;
        @(negedge clk);
        seq_check(1'b1, C_POR, 2'd1, 1'b0);

        // R10: manual request during a power-on sequence is ignored
        @(negedge clk);
        dbg_rst_req = 1'b1;
        @(negedge clk);
        dbg_rst_req = 1'b0;
        @(negedge clk);
        wdt_ovf = 1'b1; wdt_mode = 1'b1; wdt_rsel = 1'b1;
        @(negedge clk);
        wdt_ovf = 1'b0; wdt_mode = 1'b0; wdt_rsel = 1'b0;
        chk("R10 manual ignored during por", 32'({por_active_o, mrst_active_o}), 32'b10);
        chk("R10 cause unchanged", 32'(cause_o), 32'd1);
        repeat (N_INIT + 2) @(negedge clk);
        chk("R10 por finishes on time", 32'(running_o), 32'd1);

        // R10: power-on request during a manual sequence restarts as power-on
        @(negedge clk);
        wdt_ovf = 1'b1; wdt_mode = 1'b1; wdt_rsel = 1'b1;
        @(negedge clk);
        wdt_ovf = 1'b0; wdt_mode = 1'b0; wdt_rsel = 1'b0;
        chk("R8 manual started", 32'(mrst_active_o), 32'd1);
        @(negedge clk);
        dbg_rst_req = 1'b1;
        @(negedge clk);
        dbg_rst_req = 1'b0;
        chk("R10 por overrides manual", 32'({por_active_o, mrst_active_o}), 32'b10);
        chk("R10 cause now debug", 32'(cause_o), 32'd1);
        @(negedge clk);
        seq_check(1'b1, C_POR, 2'd1, 1'b0);

        // R11: pin wins over a simultaneous debug request
        @(negedge clk);
        dbg_rst_req = 1'b1;
        ext_rst_n = 1'b0;
        @(negedge clk);
        ext_rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R11 pin cause over debug", 32'(cause_o), 32'd0);
        dbg_rst_req = 1'b0;
        @(negedge clk);
        seq_check(1'b1, C_POR, 2'd0, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule